// File: doc/BRIEF.md
# I2C Configuration Register Target Port

This block is the target (slave) side of a two-wire serial control port that sits in front of a bank of 8-bit configuration registers. It oversamples the SCL and SDA lines with the system clock. It finds START, repeated START and STOP conditions on the bus and matches the device address against seven strap inputs. It then takes a register pointer byte and a data byte, acknowledging each one. For every accepted data byte it issues a one-cycle write strobe that carries the pointer and the data. The block never drives SCL. It pulls SDA low only through an open-drain pull-down enable.

A controller can follow the pointer byte with a repeated START and an address byte whose R/W bit is 1. The block then returns the register byte that the surrounding logic presents for the current pointer. It shifts the byte out MSB first and changes its output only while SCL is low. It sends the same byte again for as long as the controller acknowledges, and it lets go of SDA once the controller sends NACK. The port is active only while both mode-select inputs are high.

The state machine has ten states:

- ST_IDLE waits for a START.
- ST_DEVADDR shifts in the address byte.
- ST_DEVACK drives the address acknowledge.
- ST_PTR shifts in the pointer byte.
- ST_PTRACK drives the pointer acknowledge.
- ST_WDATA shifts in the data byte.
- ST_WDACK drives the data acknowledge and carries the write strobe.
- ST_RDATA shifts out a read byte.
- ST_RDACK samples the controller's acknowledge.
- ST_HOLD ignores the bus until the next START or STOP.

The transitions are:

- ST_IDLE goes to ST_DEVADDR on START.
- ST_DEVADDR goes to ST_DEVACK on an address match after eight bits, or to ST_HOLD on a mismatch.
- ST_DEVACK goes to ST_PTR when R/W is 0, or to ST_RDATA when R/W is 1.
- ST_PTR goes to ST_PTRACK.
- ST_PTRACK goes to ST_WDATA.
- ST_WDATA goes to ST_WDACK.
- ST_WDACK goes to ST_HOLD.
- ST_RDATA goes to ST_RDACK after eight bits.
- ST_RDACK goes back to ST_RDATA on a controller ACK, or to ST_HOLD on NACK.
- From any state, START goes to ST_DEVADDR and STOP goes to ST_IDLE.
- Dropping either mode select forces ST_IDLE.

Each of these moves happens on a falling SCL edge, except the START, STOP and mode-select moves.

Top module: `i2c_cfg_target`

## Requirements
- R1: After reset sda_pull and wr_en are low.
- R2: While mode_sel_a or mode_sel_b is low, the block never pulls SDA low, issues no write strobe, and acknowledges nothing.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Either one seen in the middle of a byte abandons that transfer and releases SDA. After a START, address reception begins afresh.
- R4: The first byte after a START holds the 7-bit device address, MSB first, followed by the R/W bit (0 = write, 1 = read). When the address equals dev_addr, the block drives SDA low during the ninth SCL pulse.
- R5: When the address does not match, the block gives no acknowledge and ignores every following byte until the next START or STOP.
- R6: On a write, the second byte is the register pointer and the third byte is the data, both MSB first, and each is acknowledged. With the data acknowledge, wr_en is high for exactly one clock, with wr_addr equal to the pointer and wr_data equal to the data.
- R7: A fourth byte in the same write is not acknowledged and produces no write strobe.
- R8: A repeated START after a write keeps the pointer. It can start a new write, or a read that returns the byte at that same pointer.
- R9: On a read, the block places rd_data (the byte at rd_addr, which equals the pointer) on SDA MSB first, and pulls SDA low for a 0 bit. sda_pull only rises while SCL is low.
- R10: When the controller acknowledges a read byte, the byte at the same pointer is sent again. On a controller NACK, the block releases SDA and stays off the bus until the next START or STOP.
- R11: Transfers work at both the 100 kHz and the 400 kHz bus rates, provided the system clock is at least 16 times the SCL rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel_a | input | 1 | First port-enable select; the port is active only when both selects are high |
| mode_sel_b | input | 1 | Second port-enable select |
| dev_addr | input | 7 | Strapped 7-bit device address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull | output | 1 | Open-drain pull-down enable for SDA |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register pointer for the write |
| wr_data | output | 8 | Data byte for the write |
| rd_addr | output | 8 | Current register pointer for the read path |
| rd_data | input | 8 | Register byte at rd_addr |

## Verification
Two situations are hardest to reach from the ports:

- A bus condition that lands in the middle of a byte.
- A repeated START that turns a write into a read without a STOP.

For the first, the bench's controller model clocks out only half of an address byte and then issues a fresh START. It then confirms that the next complete write lands correctly and that the broken byte wrote nothing.

For the second, the bench sends a START, an address and a pointer. It then issues a repeated START and the address with R/W set, and reads the byte back through the bench's own register model. This is repeated at two SCL rates, so that sampling margins at both bus speeds are exercised.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEVACK,
        ST_PTR,
        ST_PTRACK,
        ST_WDATA,
        ST_WDACK,
        ST_RDATA,
        ST_RDACK,
        ST_HOLD
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic [W-1:0] prev
);

    for (genvar g = 0; g < W; g++) begin : g_line
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], din[g]};
            end
        end

        assign level[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= '1;
        end else begin
            prev <= level;
        end
    end

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic scl_lvl,
    input  logic scl_prev,
    input  logic sda_lvl,
    input  logic sda_prev,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    logic scl_held_high;

    assign scl_held_high = scl_lvl & scl_prev;
    assign scl_rise      = scl_lvl & ~scl_prev;
    assign scl_fall      = ~scl_lvl & scl_prev;
    assign bus_start     = scl_held_high & sda_prev & ~sda_lvl;
    assign bus_stop      = scl_held_high & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
    import i2c_cfg_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int REG_W       = 8,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel_a,
    input  logic              mode_sel_b,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull,
    output logic              wr_en,
    output logic [REG_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [REG_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0] rd_data
);

    localparam int ADDR_BITS = ADDR_W + 1;
    localparam int SH_A      = (ADDR_BITS > REG_W) ? ADDR_BITS : REG_W;
    localparam int SH_W      = (SH_A > DATA_W) ? SH_A : DATA_W;
    localparam int CNT_W     = $clog2(SH_W + 1);
    localparam logic [CNT_W-1:0] LEN_ADDR = CNT_W'(ADDR_BITS);
    localparam logic [CNT_W-1:0] LEN_PTR  = CNT_W'(REG_W);
    localparam logic [CNT_W-1:0] LEN_DATA = CNT_W'(DATA_W);

    // Synchronised bus lines and conditions
    logic [1:0] line_lvl;
    logic [1:0] line_prev;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_evt;
    logic       stop_evt;
    logic       port_en;

    i2c_line_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sda_i, scl_i}),
        .level (line_lvl),
        .prev  (line_prev)
    );

    i2c_cond_detect u_cond (
        .scl_lvl   (line_lvl[0]),
        .scl_prev  (line_prev[0]),
        .sda_lvl   (line_lvl[1]),
        .sda_prev  (line_prev[1]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (start_evt),
        .bus_stop  (stop_evt)
    );

    assign port_en = mode_sel_a & mode_sel_b;

    // State and datapath registers
    tgt_state_e        state_q, state_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [SH_W-1:0]   sh_q, sh_n;
    logic [DATA_W-1:0] tx_q, tx_n;
    logic [REG_W-1:0]  ptr_q, ptr_n;
    logic [DATA_W-1:0] wdat_q, wdat_n;
    logic              pull_q, pull_n;
    logic              wr_q, wr_n;
    logic              rw_q, rw_n;
    logic              mack_q, mack_n;
    logic [SH_W-1:0]   sh_shifted;

    assign sh_shifted = {sh_q[SH_W-2:0], line_lvl[1]};

    // Next-state and next-value logic
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        sh_n    = sh_q;
        tx_n    = tx_q;
        ptr_n   = ptr_q;
        wdat_n  = wdat_q;
        pull_n  = pull_q;
        wr_n    = 1'b0;
        rw_n    = rw_q;
        mack_n  = mack_q;

        if (!port_en) begin
            state_n = ST_IDLE;
            pull_n  = 1'b0;
            cnt_n   = '0;
        end else if (start_evt) begin
            state_n = ST_DEVADDR;
            pull_n  = 1'b0;
            cnt_n   = '0;
        end else if (stop_evt) begin
            state_n = ST_IDLE;
            pull_n  = 1'b0;
            cnt_n   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_HOLD: begin
                    pull_n = 1'b0;
                end
                ST_DEVADDR: begin
                    if (scl_rise) begin
                        sh_n  = sh_shifted;
                        cnt_n = cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == LEN_ADDR) begin
                        cnt_n = '0;
                        if (sh_q[ADDR_W:1] == dev_addr) begin
                            state_n = ST_DEVACK;
                            pull_n  = 1'b1;
                            rw_n    = sh_q[0];
                        end else begin
                            state_n = ST_HOLD;
                        end
                    end
                end
                ST_DEVACK: begin
                    if (scl_fall) begin
                        cnt_n = '0;
                        if (rw_q) begin
                            state_n = ST_RDATA;
                            tx_n    = rd_data;
                            pull_n  = ~rd_data[DATA_W-1];
                        end else begin
                            state_n = ST_PTR;
                            pull_n  = 1'b0;
                        end
                    end
                end
                ST_PTR: begin
                    if (scl_rise) begin
                        sh_n  = sh_shifted;
                        cnt_n = cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == LEN_PTR) begin
                        cnt_n   = '0;
                        ptr_n   = sh_q[REG_W-1:0];
                        pull_n  = 1'b1;
                        state_n = ST_PTRACK;
                    end
                end
                ST_PTRACK: begin
                    if (scl_fall) begin
                        pull_n  = 1'b0;
                        state_n = ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (scl_rise) begin
                        sh_n  = sh_shifted;
                        cnt_n = cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == LEN_DATA) begin
                        cnt_n   = '0;
                        wdat_n  = sh_q[DATA_W-1:0];
                        wr_n    = 1'b1;
                        pull_n  = 1'b1;
                        state_n = ST_WDACK;
                    end
                end
                ST_WDACK: begin
                    if (scl_fall) begin
                        pull_n  = 1'b0;
                        state_n = ST_HOLD;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        cnt_n = cnt_q + 1'b1;
                    end else if (scl_fall) begin
                        if (cnt_q == LEN_DATA) begin
                            cnt_n   = '0;
                            pull_n  = 1'b0;
                            state_n = ST_RDACK;
                        end else begin
                            tx_n   = tx_q << 1;
                            pull_n = ~tx_q[DATA_W-2];
                        end
                    end
                end
                ST_RDACK: begin
                    if (scl_rise) begin
                        mack_n = ~line_lvl[1];
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            state_n = ST_RDATA;
                            tx_n    = rd_data;
                            pull_n  = ~rd_data[DATA_W-1];
                        end else begin
                            state_n = ST_HOLD;
                            pull_n  = 1'b0;
                        end
                    end
                end
                default: begin
                    state_n = ST_IDLE;
                    pull_n  = 1'b0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sh_q   <= '0;
            tx_q   <= '0;
            ptr_q  <= '0;
            wdat_q <= '0;
            pull_q <= 1'b0;
            wr_q   <= 1'b0;
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_n;
            sh_q   <= sh_n;
            tx_q   <= tx_n;
            ptr_q  <= ptr_n;
            wdat_q <= wdat_n;
            pull_q <= pull_n;
            wr_q   <= wr_n;
            rw_q   <= rw_n;
            mack_q <= mack_n;
        end
    end

    assign sda_pull = pull_q;
    assign wr_en    = wr_q;
    assign wr_addr  = ptr_q;
    assign wr_data  = wdat_q;
    assign rd_addr  = ptr_q;

endmodule

// File: rtl/i2c_cfg_target_checker.sv
module i2c_cfg_target_checker (
    input logic clk,
    input logic rst_n,
    input logic mode_sel_a,
    input logic mode_sel_b,
    input logic scl_i,
    input logic sda_pull,
    input logic wr_en,
    input logic stop_evt,
    input logic start_evt
);

    // R2: a disabled port lets go of SDA on the next clock
    a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_sel_a && mode_sel_b) |=> !sda_pull);

    // R2: no write strobe while the port is off
    a_r2_no_write_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(mode_sel_a && mode_sel_b));

    // R6: write strobe is a single cycle
    a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R6: the write comes together with the data acknowledge
    a_r6_strobe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_pull);

    // R9: the pull-down only starts while SCL is low
    a_r9_pull_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_i);

    // R3: STOP or START releases SDA
    a_r3_cond_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel_a && mode_sel_b && (stop_evt || start_evt)) |=> !sda_pull);

endmodule

bind i2c_cfg_target i2c_cfg_target_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel_a (mode_sel_a),
    .mode_sel_b (mode_sel_b),
    .scl_i      (scl_i),
    .sda_pull   (sda_pull),
    .wr_en      (wr_en),
    .stop_evt   (stop_evt),
    .start_evt  (start_evt)
);

// File: tb/i2c_cfg_target_bench.sv
module i2c_cfg_target_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel_a = 1'b1;
    logic       mode_sel_b = 1'b1;
    logic [6:0] dev_addr = 7'h49;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_pull;
    logic       wr_en;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;
    logic [7:0] rd_addr;
    logic [7:0] rd_data;

    logic [7:0] mem [256];
    int         wr_cnt = 0;
    int         pull_cycles = 0;
    int         checks = 0;
    int         errors = 0;
    int         half = 40;
    logic       done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;
    assign rd_data  = mem[rd_addr];

    i2c_cfg_target u_i2c_cfg_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel_a (mode_sel_a),
        .mode_sel_b (mode_sel_b),
        .dev_addr   (dev_addr),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull   (sda_pull),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    // Register model: default content is index XOR 0x5A
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
        if (sda_pull) pull_cycles <= pull_cycles + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        wait_cyc(half/2); sda_m = 1'b1;
        wait_cyc(half/2); scl_m = 1'b1;
        wait_cyc(half/2); sda_m = 1'b0;
        wait_cyc(half/2); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_cyc(half/2); sda_m = 1'b0;
        wait_cyc(half/2); scl_m = 1'b1;
        wait_cyc(half/2); sda_m = 1'b1;
        wait_cyc(half/2);
    endtask

    task automatic bus_bit(input logic b, output logic seen);
        wait_cyc(half/2); sda_m = b;
        wait_cyc(half/2); scl_m = 1'b1;
        wait_cyc(half/2); seen = sda_line;
        wait_cyc(half/2); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            bus_bit(1'b1, s);
            b = {b[6:0], s};
        end
        bus_bit(~give_ack, s);
    endtask

    task automatic t_reset();
        wait_cyc(5);
        chk("R1 sda_pull after reset", 32'(sda_pull), 0);
        chk("R1 wr_en after reset", 32'(wr_en), 0);
    endtask

    task automatic t_basic_write();
        logic a0, a1, a2;
        int   w0;
        w0 = wr_cnt;
        bus_start();
        send_byte({7'h49, 1'b0}, a0);
        send_byte(8'h6D, a1);
        send_byte(8'h4B, a2);
        bus_stop();
        chk("R4 address ack", 32'(a0), 1);
        chk("R6 pointer ack", 32'(a1), 1);
        chk("R6 data ack", 32'(a2), 1);
        chk("R6 one write strobe", 32'(wr_cnt - w0), 1);
        chk("R6 written data at pointer", 32'(mem[8'h6D]), 32'h4B);
        chk("R11 fast-rate write sda released", 32'(sda_pull), 0);
    endtask

    task automatic t_mismatch();
        logic a0, a1;
        int   w0;
        w0 = wr_cnt;
        bus_start();
        send_byte({7'h48, 1'b0}, a0);
        send_byte(8'h10, a1);
        bus_stop();
        chk("R5 no ack on wrong address", 32'(a0), 0);
        chk("R5 later byte ignored", 32'(a1), 0);
        chk("R5 no write", 32'(wr_cnt - w0), 0);
    endtask

    task automatic t_disabled();
        logic a0, a1, a2;
        int   w0, p0;
        w0 = wr_cnt;
        p0 = pull_cycles;
        mode_sel_b = 1'b0;
        bus_start();
        send_byte({7'h49, 1'b0}, a0);
        send_byte(8'h05, a1);
        send_byte(8'hEE, a2);
        bus_stop();
        chk("R2 no ack while disabled", 32'({a0, a1, a2}), 0);
        chk("R2 no pull while disabled", 32'(pull_cycles - p0), 0);
        chk("R2 no write while disabled", 32'(wr_cnt - w0), 0);
        chk("R2 register untouched", 32'(mem[8'h05]), 32'(8'h05 ^ 8'h5A));
        mode_sel_b = 1'b1;
    endtask

    task automatic t_extra_byte();
        logic a0, a1, a2, a3;
        int   w0;
        w0 = wr_cnt;
        bus_start();
        send_byte({7'h49, 1'b0}, a0);
        send_byte(8'h22, a1);
        send_byte(8'h33, a2);
        send_byte(8'h44, a3);
        bus_stop();
        chk("R7 fourth byte not acked", 32'(a3), 0);
        chk("R7 single write only", 32'(wr_cnt - w0), 1);
        chk("R7 data kept", 32'(mem[8'h22]), 32'h33);
    endtask

    task automatic t_rs_read_same();
        logic       a0, a1, a2, a3;
        logic [7:0] r0, r1;
        bus_start();
        send_byte({7'h49, 1'b0}, a0);
        send_byte(8'h20, a1);
        send_byte(8'hA5, a2);
        bus_start();
        send_byte({7'h49, 1'b1}, a3);
        recv_byte(1'b1, r0);
        recv_byte(1'b0, r1);
        wait_cyc(8);
        chk("R10 sda released after NACK", 32'(sda_pull), 0);
        bus_stop();
        chk("R8 read address acked", 32'(a3), 1);
        chk("R8 read of same pointer", 32'(r0), 32'hA5);
        chk("R10 acked read resends byte", 32'(r1), 32'hA5);
    endtask

    task automatic t_rs_new_write();
        logic a0, a1, a2, a3, a4, a5;
        bus_start();
        send_byte({7'h49, 1'b0}, a0);
        send_byte(8'h30, a1);
        send_byte(8'h11, a2);
        bus_start();
        send_byte({7'h49, 1'b0}, a3);
        send_byte(8'h31, a4);
        send_byte(8'h22, a5);
        bus_stop();
        chk("R8 first write", 32'(mem[8'h30]), 32'h11);
        chk("R8 second write after repeated START", 32'(mem[8'h31]), 32'h22);
        chk("R8 all acked", 32'({a3, a4, a5}), 32'h7);
    endtask

    task automatic t_read_new_ptr();
        logic       a0, a1, a2;
        logic [7:0] r0;
        bus_start();
        send_byte({7'h49, 1'b0}, a0);
        send_byte(8'h7F, a1);
        bus_start();
        send_byte({7'h49, 1'b1}, a2);
        recv_byte(1'b0, r0);
        bus_stop();
        chk("R9 read of new pointer", 32'(r0), 32'(8'h7F ^ 8'h5A));
        chk("R9 rd_addr equals pointer", 32'(rd_addr), 32'h7F);
    endtask

    task automatic t_abort();
        logic s, a0, a1, a2;
        int   w0;
        w0 = wr_cnt;
        bus_start();
        bus_bit(1'b1, s);
        bus_bit(1'b0, s);
        bus_bit(1'b0, s);
        bus_bit(1'b1, s);
        bus_start();
        chk("R3 no write from broken byte", 32'(wr_cnt - w0), 0);
        send_byte({7'h49, 1'b0}, a0);
        send_byte(8'h40, a1);
        send_byte(8'h99, a2);
        bus_stop();
        chk("R3 restart acks", 32'({a0, a1, a2}), 32'h7);
        chk("R3 write after abort", 32'(mem[8'h40]), 32'h99);
    endtask

    task automatic t_standard_rate();
        logic       a0, a1, a2, a3;
        logic [7:0] r0;
        half = 160;
        bus_start();
        send_byte({7'h49, 1'b0}, a0);
        send_byte(8'h55, a1);
        send_byte(8'hC3, a2);
        bus_start();
        send_byte({7'h49, 1'b1}, a3);
        recv_byte(1'b0, r0);
        bus_stop();
        chk("R11 slow-rate acks", 32'({a0, a1, a2, a3}), 32'hF);
        chk("R11 slow-rate readback", 32'(r0), 32'hC3);
        half = 40;
    endtask

    task automatic t_strap();
        logic a0, a1;
        dev_addr = 7'h4A;
        wait_cyc(4);
        bus_start();
        send_byte({7'h49, 1'b0}, a0);
        bus_stop();
        bus_start();
        send_byte({7'h4A, 1'b0}, a1);
        bus_stop();
        chk("R4 old strap value rejected", 32'(a0), 0);
        chk("R4 new strap value acked", 32'(a1), 1);
        dev_addr = 7'h49;
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        t_reset();
        t_basic_write();
        t_mismatch();
        t_disabled();
        t_extra_byte();
        t_rs_read_same();
        t_rs_new_write();
        t_read_new_ptr();
        t_abort();
        t_standard_rate();
        t_strap();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule